// File: doc/BRIEF.md
# N-Chance Clock Victim Selector

This block chooses which physical frame gives up its page when a page fault needs room. The frames form a ring, and a hand points at one of them. Each frame holds a use bit, which the block sets whenever a reference strobe names that frame. Each frame also holds a small skip counter. When a fault request arrives, the hand moves forward one frame per clock cycle and examines the frame it reaches. A recently used frame has its use bit cleared, its counter zeroed, and is passed by. An unused frame has its counter raised by one. The first frame whose raised count reaches the threshold N becomes the victim.

With N at 1 the block acts as the plain second-chance clock. Larger N values keep a frame in place until it has been passed over N times without being touched. The caller pulses the fault request, waits for the done pulse, and reads the victim index. The hand stays on the victim until the next fault.

Top module: `nchance_clock_victim`

## Requirements
- R1: After reset, victimFrame reads 15 (the last frame), victimDone is 0, and every use bit and counter is 0, so the first scan begins at frame 0.
- R2: A cycle with refValid high sets the use bit of the frame given by refFrame.
- R3: A scan examines exactly one frame per cycle, at index hand+1 modulo 16, and the hand moves onto that frame. Outside a scan the hand does not move.
- R4: An examined frame whose use bit is 1 gets its use bit cleared and its counter set to 0, and the scan continues.
- R5: An examined frame whose use bit is 0 gets its counter raised by one. If the raised value is still below N the scan continues; otherwise that frame is the victim. Counters keep their values between scans.
- R6: With N = 1 the first examined frame that has a clear use bit is chosen. An N of 0 is treated as 1.
- R7: victimDone is high for exactly one cycle, in the cycle after the clock edge that examined the victim, and victimFrame then shows the victim index. victimFrame holds that index until the next scan moves the hand.
- R8: The victim frame's counter is reset to 0 and its use bit is cleared, unless a reference arrives in that same cycle.
- R9: When a reference and a clear from the scan hit the same frame in the same cycle, the reference wins and the use bit ends at 1.
- R10: faultReq is accepted only while no scan is running. thresholdN is sampled when the fault is accepted, and changes made during the scan have no effect.
- R11: Every scan ends within (N+1)*16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | Reference strobe |
| refFrame | input | 4 | Frame index being referenced |
| faultReq | input | 1 | Request to find a victim |
| thresholdN | input | 3 | Skip threshold N (1 to 7; 0 is treated as 1) |
| victimFrame | output | 4 | Current hand position, which is the victim index when done |
| victimDone | output | 1 | One-cycle pulse marking that a victim was chosen |

## Verification
The bench counts the cycles from fault to done. An off-by-one in the hand start point, or a compare of the old count against N instead of the raised count, therefore shows up as a wrong cycle count or a wrong victim. It lowers N partway through a long scan and pulses a second fault during the scan. A design that tracks thresholdN live, or restarts on a new fault, would stop early at a different frame. It references a frame in the same cycle the hand clears it and then walks the ring back to that frame. A design that lets the clear win would pick that frame one cycle early. It also lowers N between faults while counters stay high, and it checks that an N of 0 behaves as 1.

// File: rtl/nchance_pkg.sv
package nchance_pkg;
  // strobes from the scan control to the frame datapath
  typedef struct packed {
    logic start;  // latch threshold, scan begins next cycle
    logic step;   // examine frame after hand and move onto it
    logic pick;   // examined frame is the victim
  } scanCmd_t;
endpackage

// File: rtl/nchance_frame_dp.sv
module nchance_frame_dp
  import nchance_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int CNT_W  = 3,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scanCmd_t         cmd,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  input  logic [CNT_W-1:0] thresholdN,
  output logic             nextUse,
  output logic             nextHit,
  output logic [IDX_W-1:0] hand
);
  logic             useArr [FRAMES];
  logic [CNT_W-1:0] cntArr [FRAMES];
  logic [CNT_W-1:0] thrQ;
  logic [IDX_W-1:0] nextIdx;

  assign nextIdx = (hand == IDX_W'(FRAMES - 1)) ? '0 : hand + 1'b1;
  assign nextUse = useArr[nextIdx];
  assign nextHit = ({1'b0, cntArr[nextIdx]} + 1'b1) >= {1'b0, thrQ};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hand <= IDX_W'(FRAMES - 1);
      thrQ <= CNT_W'(1);
    end else begin
      if (cmd.start) thrQ <= (thresholdN == '0) ? CNT_W'(1) : thresholdN;
      if (cmd.step)  hand <= nextIdx;
    end
  end

  for (genvar i = 0; i < FRAMES; i++) begin : g_frame
    logic sel;
    logic hit;
    assign sel = cmd.step && (nextIdx == IDX_W'(i));
    assign hit = refValid && (refFrame == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        useArr[i] <= 1'b0;
        cntArr[i] <= '0;
      end else begin
        if (sel) begin
          if (useArr[i] || cmd.pick) cntArr[i] <= '0;
          else                       cntArr[i] <= cntArr[i] + 1'b1;
        end
        if (hit)      useArr[i] <= 1'b1;  // reference beats clear
        else if (sel) useArr[i] <= 1'b0;
      end
    end
  end

  p_ref_sets_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refValid |=> useArr[$past(refFrame)]);
  p_ref_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && cmd.step && refFrame == nextIdx) |=> useArr[$past(nextIdx)]);
  p_pass_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.step && nextUse && !(refValid && refFrame == nextIdx))
      |=> (!useArr[$past(nextIdx)] && cntArr[$past(nextIdx)] == '0));
  p_hand_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.step |=> hand == $past(nextIdx));
  p_hand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.step |=> $stable(hand));
  p_victim_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.pick |=> cntArr[$past(nextIdx)] == '0);
endmodule

// File: rtl/nchance_scan_ctrl.sv
module nchance_scan_ctrl
  import nchance_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int CNT_W  = 3,
  localparam int BOUND = (2 ** CNT_W) * FRAMES,
  localparam int LEN_W = $clog2(BOUND + 2)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     faultReq,
  input  logic     nextUse,
  input  logic     nextHit,
  output scanCmd_t cmd,
  output logic     victimDone
);
  typedef enum logic {ST_IDLE, ST_SCAN} scanState_t;
  scanState_t state;
  logic [LEN_W-1:0] scanLen;

  always_comb begin
    cmd.start = (state == ST_IDLE) && faultReq;
    cmd.step  = (state == ST_SCAN);
    cmd.pick  = cmd.step && !nextUse && nextHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      victimDone <= 1'b0;
      scanLen    <= '0;
    end else begin
      victimDone <= cmd.pick;
      if (cmd.start) begin
        state   <= ST_SCAN;
        scanLen <= '0;
      end else if (cmd.step) begin
        scanLen <= scanLen + 1'b1;
        if (cmd.pick) state <= ST_IDLE;
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victimDone |=> !victimDone);
  p_scan_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    scanLen <= LEN_W'(BOUND));
  p_fault_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN && !cmd.pick) |=> (state == ST_SCAN && !victimDone));
endmodule

// File: rtl/nchance_clock_victim.sv
module nchance_clock_victim
  import nchance_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int CNT_W  = 3,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  input  logic             faultReq,
  input  logic [CNT_W-1:0] thresholdN,
  output logic [IDX_W-1:0] victimFrame,
  output logic             victimDone
);
  scanCmd_t cmd;
  logic     nextUse;
  logic     nextHit;

  nchance_scan_ctrl #(.FRAMES(FRAMES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .faultReq(faultReq),
    .nextUse(nextUse), .nextHit(nextHit),
    .cmd(cmd), .victimDone(victimDone)
  );

  nchance_frame_dp #(.FRAMES(FRAMES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .refValid(refValid), .refFrame(refFrame), .thresholdN(thresholdN),
    .nextUse(nextUse), .nextHit(nextHit), .hand(victimFrame)
  );
endmodule

// File: tb/nchance_clock_victim_bench.sv
module nchance_clock_victim_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refValid = 1'b0;
  logic [3:0] refFrame = '0;
  logic       faultReq = 1'b0;
  logic [2:0] thresholdN = 3'd1;
  logic [3:0] victimFrame;
  logic       victimDone;
  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  always #5 clk = ~clk;

  nchance_clock_victim u_nchance_clock_victim (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .refFrame(refFrame),
    .faultReq(faultReq), .thresholdN(thresholdN),
    .victimFrame(victimFrame), .victimDone(victimDone)
  );

  // {reference mask[15:0], N[2:0], victim[3:0], cycles[7:0]}
  localparam int NVEC = 7;
  localparam logic [30:0] VEC [NVEC] = '{
    {16'h0000, 3'd1, 4'd0, 8'd1},   // R6 nothing used, N=1
    {16'h0006, 3'd1, 4'd3, 8'd3},   // R4 skip two used frames
    {16'h0000, 3'd2, 4'd4, 8'd17},  // R5 one full lap to build counts
    {16'h0020, 3'd2, 4'd6, 8'd2},   // R4/R5 used frame resets its count
    {16'hFFFF, 3'd1, 4'd7, 8'd17},  // R11 every frame used
    {16'h0000, 3'd7, 4'd8, 8'd97},  // R11 worst lap count for N=7
    {16'h0000, 3'd3, 4'd9, 8'd1}    // R5 counts persist, N lowered
  };

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    refValid = 1'b1;
    refFrame = 4'(f);
    @(negedge clk);
    refValid = 1'b0;
  endtask

  // fault; optional ref in first scan cycle; mid-scan disturbance if long
  task automatic runFault(input int n, input int refAtStart, input int expV,
                          input int expC, input string req);
    int cycles;
    @(negedge clk);
    thresholdN = 3'(n);
    faultReq = 1'b1;
    @(negedge clk);
    faultReq = 1'b0;
    if (refAtStart >= 0) begin
      refValid = 1'b1;
      refFrame = 4'(refAtStart);
    end
    cycles = 0;
    while (!victimDone && cycles < 300) begin
      @(negedge clk);
      refValid = 1'b0;
      cycles = cycles + 1;
      if (cycles == 2 && expC > 4 && !victimDone) begin
        faultReq = 1'b1;     // R10 ignored while scanning
        thresholdN = 3'd1;   // R10 not resampled
      end else begin
        faultReq = 1'b0;
      end
    end
    check(victimFrame == 4'(expV), {req, " victim"}, victimFrame, expV);
    check(cycles == expC, {req, " cycles"}, cycles, expC);
    @(negedge clk);
    check(!victimDone, "R7 done pulse one cycle", victimDone, 0);
    check(victimFrame == 4'(expV), "R7 victim held", victimFrame, expV);
  endtask

  initial begin
    doReset();
    check(victimFrame == 4'd15, "R1 reset hand", victimFrame, 15);
    check(!victimDone, "R1 reset done", victimDone, 0);

    for (int v = 0; v < NVEC; v++) begin
      for (int f = 0; f < 16; f++)
        if (VEC[v][30 - 15 + f]) touch(f);  // R2 references
      runFault(int'(VEC[v][14:12]), -1, int'(VEC[v][11:8]), int'(VEC[v][7:0]),
               "R3 R5 vector");
    end

    // R9: reference to frame 0 in the cycle the hand clears it
    doReset();
    touch(0);
    touch(1);
    runFault(1, 0, 2, 3, "R9 setup");
    for (int f = 3; f < 16; f++) touch(f);
    runFault(1, -1, 1, 15, "R9 reference beats clear");

    // R6: N of zero acts as one
    doReset();
    runFault(0, -1, 0, 1, "R6 N zero");

    // R8: victim use bit cleared, so with N=1 it comes round again after one lap
    doReset();
    for (int f = 0; f < 16; f++) touch(f);
    runFault(1, -1, 0, 17, "R8 all used");
    for (int f = 1; f < 16; f++) touch(f);
    runFault(1, -1, 0, 16, "R8 victim reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule